// File: doc/BRIEF.md
# PWM-Gated Pulse-Density Audio Channel

This block converts one audio channel into a single-bit pulse-density stream. The inputs are a signed 8-bit sample and a 7-bit volume word. An 8-bit first-order accumulator advances once per audio clock enable, and its carry out becomes the output bit. The density of ones therefore tracks the sample value.

Volume is not applied by a multiplier. A free-running 6-bit slot counter forms a PWM gate. In each enabled step the gate selects what is added to the accumulator: either the current sample or zero. The low six volume bits set how many of the 64 slots pass the sample. The top volume bit forces the gate open permanently, so the block has 65 volume states.

The sample and volume are plain level inputs. They are read on every enabled step, so software may change them at any time without disturbing the accumulator. The enable is a one-cycle strobe at the audio rate, roughly 3.57 MHz, derived from the much faster system clock.

Top module: `pdm_volume_channel`

## Requirements
- R1: While `rst_n` is low, the accumulator and the slot counter are cleared and `pdm_out` is 0.
- R2: In a cycle with `audio_ce` low, `pdm_out`, the accumulator and the slot counter keep their values, whatever `sample_in` and `volume_in` do.
- R3: The signed sample is mapped to an unsigned addend by inverting bit 7. A sample of 0x00 at full volume, starting from reset, yields exactly 128 ones in 256 enabled steps.
- R4: On each enabled step, `pdm_out` becomes the carry out of the 8-bit sum of the accumulator and the addend, registered at that edge. Sample 0x81 (addend 1) at full volume, starting from reset, yields exactly one 1 in 256 enabled steps.
- R5: The 6-bit slot counter starts at 0 after reset, increments by one on each enabled step and wraps from 63 to 0. The gate is open when the counter is below `volume_in[5:0]`. When the gate is closed, zero is added: the accumulator holds and `pdm_out` becomes 0.
- R6: When `volume_in[6]` is 1, the gate is open on every enabled step, whatever the value of bits 5..0.
- R7: With `volume_in` equal to 0, `pdm_out` is 0 after every enabled step.
- R8: A new sample value takes effect at the next enabled step, and the accumulator keeps its running value across the change.
- R9: Sample 0x7F (addend 0xFF) at full volume, starting from reset, yields exactly 255 ones in 256 enabled steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| audio_ce | input | 1 | One-cycle strobe that advances the modulator by one step |
| sample_in | input | 8 | Signed two's-complement sample |
| volume_in | input | 7 | Bit 6 selects full volume; bits 5..0 give the open-slot count |
| pdm_out | output | 1 | Pulse-density output bit |

## Verification
The hardest state to reach from the ports is one where the PWM slot position and the accumulator residue line up so that a volume or sample change lands mid-period with a partial sum still pending. Only then do R5 and R8 interact. The stimulus handles this in three ways. It runs exact 256-step windows from reset to pin down the density counts. It swaps the sample after a short run, so a carry can appear only if the residue was kept. Finally, it drives a long pseudo-random sequence of enables, samples and volumes, including gaps in `audio_ce`, against a behavioural step model that is compared every cycle.

// File: rtl/pdm_chan_pkg.sv
package pdm_chan_pkg;
  localparam int unsigned SAMPLE_W_DEF = 8;
  localparam int unsigned SLOT_W_DEF   = 6;
endpackage

// File: rtl/pdm_slot_gate.sv
module pdm_slot_gate #(
  parameter int unsigned SLOT_W = pdm_chan_pkg::SLOT_W_DEF,
  localparam int unsigned LVL_W = SLOT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic [LVL_W-1:0]  level,
  output logic [SLOT_W-1:0] slot_q,
  output logic              open
);
  logic force_full;
  logic below;

  assign force_full = level[SLOT_W];
  assign below      = (slot_q < level[SLOT_W-1:0]);
  assign open       = force_full | below;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    slot_q <= '0;
    else if (step) slot_q <= slot_q + 1'b1;
  end
endmodule

// File: rtl/pdm_addend_sel.sv
module pdm_addend_sel #(
  parameter int unsigned SAMPLE_W = pdm_chan_pkg::SAMPLE_W_DEF
) (
  input  logic [SAMPLE_W-1:0] sample,
  input  logic                pass,
  output logic [SAMPLE_W-1:0] addend
);
  logic [SAMPLE_W-1:0] biased;

  assign biased = {~sample[SAMPLE_W-1], sample[SAMPLE_W-2:0]};
  assign addend = pass ? biased : '0;
endmodule

// File: rtl/pdm_carry_accum.sv
module pdm_carry_accum #(
  parameter int unsigned ACC_W = pdm_chan_pkg::SAMPLE_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [ACC_W-1:0] addend,
  output logic [ACC_W-1:0] acc_q,
  output logic             carry_q
);
  logic [ACC_W:0] sum;

  assign sum = {1'b0, acc_q} + {1'b0, addend};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      carry_q <= 1'b0;
    end else if (step) begin
      acc_q   <= sum[ACC_W-1:0];
      carry_q <= sum[ACC_W];
    end
  end
endmodule

// File: rtl/pdm_volume_channel.sv
module pdm_volume_channel #(
  parameter int unsigned SAMPLE_W = pdm_chan_pkg::SAMPLE_W_DEF,
  parameter int unsigned SLOT_W   = pdm_chan_pkg::SLOT_W_DEF,
  localparam int unsigned VOL_W   = SLOT_W + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                audio_ce,
  input  logic [SAMPLE_W-1:0] sample_in,
  input  logic [VOL_W-1:0]    volume_in,
  output logic                pdm_out
);
  logic [SLOT_W-1:0]   pwm_count;
  logic                gate_open;
  logic [SAMPLE_W-1:0] addend;
  logic [SAMPLE_W-1:0] acc_q;

  pdm_slot_gate #(.SLOT_W(SLOT_W)) gate_i (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (audio_ce),
    .level (volume_in),
    .slot_q(pwm_count),
    .open  (gate_open)
  );

  pdm_addend_sel #(.SAMPLE_W(SAMPLE_W)) sel_i (
    .sample(sample_in),
    .pass  (gate_open),
    .addend(addend)
  );

  pdm_carry_accum #(.ACC_W(SAMPLE_W)) acc_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .step   (audio_ce),
    .addend (addend),
    .acc_q  (acc_q),
    .carry_q(pdm_out)
  );
endmodule

// File: rtl/pdm_volume_channel_chk.sv
module pdm_volume_channel_chk #(
  parameter int unsigned SAMPLE_W = 8,
  parameter int unsigned SLOT_W   = 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic                audio_ce,
  input logic [SLOT_W:0]     volume_in,
  input logic                pdm_out,
  input logic [SLOT_W-1:0]   pwm_count,
  input logic                gate_open,
  input logic [SAMPLE_W-1:0] acc_q
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (acc_q == '0 && pwm_count == '0 && !pdm_out));

  assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !audio_ce |=> ($stable(pdm_out) && $stable(acc_q) && $stable(pwm_count)));

  assert_slot_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
    audio_ce |=> pwm_count == SLOT_W'($past(pwm_count) + 1'b1));

  assert_closed_adds_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (audio_ce && !gate_open) |=> (!pdm_out && $stable(acc_q)));

  assert_full_forces_open_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (audio_ce && volume_in[SLOT_W]) |-> gate_open);

  assert_mute_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (audio_ce && volume_in == '0) |=> !pdm_out);
endmodule

bind pdm_volume_channel pdm_volume_channel_chk #(.SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .audio_ce (audio_ce),
  .volume_in(volume_in),
  .pdm_out  (pdm_out),
  .pwm_count(pwm_count),
  .gate_open(gate_open),
  .acc_q    (acc_q)
);

// File: tb/pdm_volume_channel_tb.sv
module pdm_volume_channel_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       audio_ce = 1'b0;
  logic [7:0] sample_in = 8'h00;
  logic [6:0] volume_in = 7'h40;
  logic       pdm_out;

  int checks = 0;
  int errors = 0;
  int m_acc = 0;
  int m_cnt = 0;
  int m_pdm = 0;

  always #4 clk = ~clk;

  pdm_volume_channel dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .audio_ce (audio_ce),
    .sample_in(sample_in),
    .volume_in(volume_in),
    .pdm_out  (pdm_out)
  );

  task automatic check(string tag, int actual, int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, actual, expected, $time);
    end
  endtask

  task automatic model_step();
    int add;
    int sum;
    bit open;
    if (!rst_n) begin
      m_acc = 0; m_cnt = 0; m_pdm = 0;
    end else if (audio_ce) begin
      open = volume_in[6] || (m_cnt < int'(volume_in[5:0]));
      add  = open ? int'(sample_in ^ 8'h80) : 0;
      sum  = m_acc + add;
      m_pdm = (sum >= 256) ? 1 : 0;
      m_acc = sum % 256;
      m_cnt = (m_cnt + 1) % 64;
    end
  endtask

  // one clock: model advances at the edge, outputs compared at the falling edge
  task automatic cyc(string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    check(tag, int'(pdm_out), m_pdm);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cyc("R1 reset");
    cyc("R1 reset");
    check("R1 reset output", int'(pdm_out), 0);
    rst_n = 1'b1;
  endtask

  task automatic count_ones(string tag, int n, output int ones);
    ones = 0;
    for (int i = 0; i < n; i++) begin
      cyc(tag);
      ones += int'(pdm_out);
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired (all requirements) actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int ones;
    int held;
    logic [15:0] lfsr;
    @(negedge clk);
    do_reset();

    // R4: addend 1 at full volume
    audio_ce = 1'b1; volume_in = 7'h40; sample_in = 8'h81;
    count_ones("R4 unit addend", 256, ones);
    check("R4 ones in 256", ones, 1);

    // R9: full scale
    do_reset();
    audio_ce = 1'b1; sample_in = 8'h7F;
    count_ones("R9 full scale", 256, ones);
    check("R9 ones in 256", ones, 255);

    // R3: zero sample maps to mid scale
    do_reset();
    audio_ce = 1'b1; sample_in = 8'h00;
    count_ones("R3 mid scale", 256, ones);
    check("R3 ones in 256", ones, 128);

    // R7: muted
    do_reset();
    audio_ce = 1'b1; volume_in = 7'h00; sample_in = 8'h7F;
    count_ones("R7 mute", 200, ones);
    check("R7 ones while muted", ones, 0);

    // R6: bit 6 overrides low bits
    do_reset();
    audio_ce = 1'b1; volume_in = 7'h7F; sample_in = 8'h81;
    count_ones("R6 forced full", 256, ones);
    check("R6 ones in 256", ones, 1);
    do_reset();
    audio_ce = 1'b1; volume_in = 7'h40; sample_in = 8'h7F;
    count_ones("R6 forced full scale", 256, ones);
    check("R6 full-scale ones", ones, 255);

    // R5: partial volume gating
    do_reset();
    audio_ce = 1'b1; volume_in = 7'h3F; sample_in = 8'h7F;
    count_ones("R5 63 of 64 slots", 256, ones);
    do_reset();
    audio_ce = 1'b1; volume_in = 7'h01; sample_in = 8'h7F;
    count_ones("R5 one slot", 256, ones);
    check("R5 single-slot ones", ones, 3);

    // R8: residue kept across sample change
    do_reset();
    audio_ce = 1'b1; volume_in = 7'h40; sample_in = 8'h81;
    count_ones("R8 prefill", 10, ones);
    check("R8 no carry during prefill", ones, 0);
    sample_in = 8'h7F;
    cyc("R8 new sample");
    check("R8 carry from kept residue", int'(pdm_out), 1);

    // R2: idle cycles hold everything
    do_reset();
    audio_ce = 1'b1; sample_in = 8'h40;
    count_ones("R2 run", 7, ones);
    held = int'(pdm_out);
    audio_ce = 1'b0;
    for (int i = 0; i < 12; i++) begin
      sample_in = 8'(i * 37);
      volume_in = 7'(i * 11);
      cyc("R2 idle");
      check("R2 output held", int'(pdm_out), held);
    end
    volume_in = 7'h40;
    audio_ce = 1'b1;
    count_ones("R2 resume", 20, ones);

    // mixed stimulus against the model
    do_reset();
    lfsr = 16'hACE1;
    for (int i = 0; i < 4000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      audio_ce = (lfsr[2:0] != 3'd0);
      if (lfsr[7:4] == 4'd0) sample_in = lfsr[15:8];
      if (lfsr[11:8] == 4'd3) volume_in = lfsr[14:8];
      cyc("R5 R8 mixed");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule